// File: doc/BRIEF.md
# Keypad Tone Steering and Digit Latch

This block is the digital back end of a dual-tone keypad receiver. An upstream frequency classifier gives it a presence flag, which is high while a valid pair of tones is heard together. It also gives a 4-bit code that names which of the 16 keypad pairs is present. The block checks how long the presence flag stays high before it accepts a digit. It then latches the code, drives a guard flag and, after a short settling delay, raises a digit-valid flag.

The block measures the silence that ends a digit in the same way. The tone must stay absent for a programmable number of cycles before the digit is closed and the next one can be taken. A short burst of tone therefore never produces a digit, and a short dropout inside a tone never splits one digit into two.

Acquisition and release times are two separate cycle counts supplied at the ports. A read-enable input gates the latched code onto the output bus, in the manner of a three-state port. A companion output tells when that bus is driven.

Top module: `tone_steer`

## Requirements
- R1: After reset, `digit_valid` and `guard` are 0 and the latched code is 0, so `bus_code` reads 0 even when `bus_oe` is high.
- R2: While no digit is held, the block latches `tone_code` when `tone_present` has been high for `acq_len` consecutive cycles. The value latched is the one sampled on the last of those cycles. Any of the 16 code values 0..15 is stored unchanged.
- R3: A presence burst shorter than `acq_len` cycles leaves the latched code and all flags unchanged.
- R4: `guard` is high in the cycle after each clock edge that holds a digit and samples `tone_present` high. It is 0 otherwise, and it falls one cycle after `tone_present` is sampled low.
- R5: `digit_valid` rises `SETTLE` clock cycles after the edge that loads the latch, as long as the digit is still held at that time.
- R6: A held digit is released, and `digit_valid` falls, after `tone_present` has been low for `rel_len` consecutive cycles. A dropout shorter than that does not release the digit.
- R7: While a digit is held, changes on `tone_code` do not alter the latched code. A new digit can only be acquired after the release.
- R8: `bus_code` equals the latched code while `bus_oe` is 1 and is 0 while `bus_oe` is 0. `bus_drive` follows `bus_oe`.
- R9: A value of 0 on `acq_len` or `rel_len` acts as 1, so a single qualifying cycle is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tone_present | input | 1 | High while the classifier sees a valid tone pair |
| tone_code | input | CODE_W (4) | Code of the present tone pair |
| acq_len | input | CNT_W (8) | Consecutive present cycles needed to accept a digit |
| rel_len | input | CNT_W (8) | Consecutive absent cycles needed to close a digit |
| bus_oe | input | 1 | Read enable for the output bus |
| bus_code | output | CODE_W (4) | Latched code, or 0 when not enabled |
| bus_drive | output | 1 | High when the bus is driven |
| guard | output | 1 | Digit held and tone still present |
| digit_valid | output | 1 | Delayed flag that a digit is registered |

## Verification
The bench runs presence bursts one cycle short of and exactly equal to the acquisition count, and dropouts one cycle short of and equal to the release count. A design with an off-by-one counter would accept a short burst, or split a digit on a short dropout. It changes `tone_code` while a digit is held, which catches a latch that keeps loading after acquisition. It also sets both counts to zero, where a counter that compares for equality would wait through a full wraparound. Random runs with random counts and random bus enables check the settling delay: a design that raises `digit_valid` with the latch, or that clears it while the tone drops out, shows up there as a mismatch.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } steer_state_t;
endpackage

// File: rtl/tsl_run_counter.sv
// Counts consecutive cycles of 'run'; 'reach' marks the cycle that completes the run.
module tsl_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             reach
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign reach   = run && (cnt_inc >= {1'b0, limit});

  always_comb begin
    if (!run || reach) cnt_n = '0;
    else               cnt_n = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/tsl_settle_delay.sv
// Raises 'flag' a fixed number of edges after 'start' while 'arm' stays high.
module tsl_settle_delay #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic start,
  output logic flag
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SET_V = SW'(SETTLE);

  logic [SW-1:0] sc_q, sc_n;
  logic          flag_q, flag_n;

  always_comb begin
    if (!arm || start)      sc_n = '0;
    else if (sc_q == SET_V) sc_n = sc_q;
    else                    sc_n = sc_q + SW'(1);
    flag_n = arm && (sc_n == SET_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      sc_q   <= sc_n;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/tone_steer.sv
module tone_steer
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tone_present,
  input  logic [CODE_W-1:0] tone_code,
  input  logic [CNT_W-1:0]  acq_len,
  input  logic [CNT_W-1:0]  rel_len,
  input  logic              bus_oe,
  output logic [CODE_W-1:0] bus_code,
  output logic              bus_drive,
  output logic              guard,
  output logic              digit_valid
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  steer_state_t      state_q, state_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              guard_q, guard_n;
  logic              run, reach, latch_en, release_ev;
  logic [CNT_W-1:0]  limit;

  // one counter serves both directions: presence while idle, absence while held
  always_comb begin
    if (state_q == ST_IDLE) begin
      run   = tone_present;
      limit = acq_len;
    end else begin
      run   = !tone_present;
      limit = rel_len;
    end
  end

  tsl_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (run),
    .limit (limit),
    .reach (reach)
  );

  assign latch_en   = (state_q == ST_IDLE) && reach;
  assign release_ev = (state_q == ST_HELD) && reach;

  always_comb begin
    state_n = state_q;
    if (latch_en)   state_n = ST_HELD;
    if (release_ev) state_n = ST_IDLE;
    code_n  = latch_en ? tone_code : code_q;
    guard_n = (state_n == ST_HELD) && tone_present;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      guard_q <= 1'b0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      guard_q <= guard_n;
    end
  end

  tsl_settle_delay #(.SETTLE(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_i),
    .arm   (state_n == ST_HELD),
    .start (latch_en),
    .flag  (digit_valid)
  );

  assign guard     = guard_q;
  assign bus_drive = bus_oe;
  assign bus_code  = bus_oe ? code_q : '0;
endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tone_present,
  input logic              bus_oe,
  input logic [CODE_W-1:0] bus_code,
  input logic              guard,
  input logic              digit_valid
);
  AST_GUARD_NEEDS_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    guard |-> $past(tone_present)); // R4

  AST_BUS_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_code == '0)); // R8

  AST_CODE_HELD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_valid && $past(digit_valid) && bus_oe && $past(bus_oe)) |-> $stable(bus_code)); // R7

  AST_VALID_FALLS_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(digit_valid) |-> !$past(tone_present)); // R6
endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tone_present (tone_present),
  .bus_oe       (bus_oe),
  .bus_code     (bus_code),
  .guard        (guard),
  .digit_valid  (digit_valid)
);

// File: tb/tone_steer_tb.sv
`timescale 1ns/1ps
module tone_steer_tb;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 8;
  localparam int SETTLE = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tone_present;
  logic [CODE_W-1:0] tone_code;
  logic [CNT_W-1:0]  acq_len, rel_len;
  logic              bus_oe;
  logic [CODE_W-1:0] bus_code;
  logic              bus_drive, guard, digit_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tone_steer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tone_present(tone_present), .tone_code(tone_code),
    .acq_len(acq_len), .rel_len(rel_len), .bus_oe(bus_oe), .bus_code(bus_code),
    .bus_drive(bus_drive), .guard(guard), .digit_valid(digit_valid));

  // reference state, built from the requirements
  bit       m_held;
  int       m_cnt, m_sc;
  bit [3:0] m_code;
  bit       m_guard, m_dv;

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic model_step(input bit tp, input bit [3:0] tc);
    bit next_held = m_held;
    bit started   = 1'b0;
    if (!m_held) begin
      if (tp) begin
        if (m_cnt + 1 >= eff(acq_len)) begin
          next_held = 1'b1; m_code = tc; m_cnt = 0; started = 1'b1;
        end else m_cnt++;
      end else m_cnt = 0;
    end else begin
      if (!tp) begin
        if (m_cnt + 1 >= eff(rel_len)) begin
          next_held = 1'b0; m_cnt = 0;
        end else m_cnt++;
      end else m_cnt = 0;
    end
    if (!next_held || started) m_sc = 0;
    else if (m_sc < SETTLE)    m_sc++;
    m_held  = next_held;
    m_guard = m_held && tp;
    m_dv    = m_held && (m_sc == SETTLE);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R8 bus_code", bus_code, bus_oe ? m_code : 0);
    check("R8 bus_drive", bus_drive, bus_oe);
    check("R4 guard", guard, m_guard);
    check("R5/R6 digit_valid", digit_valid, m_dv);
  endtask

  task automatic step(input bit tp, input bit [3:0] tc, input bit oe);
    tone_present = tp; tone_code = tc; bus_oe = oe;
    model_step(tp, tc);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tone_present = 1'b0; tone_code = '0; bus_oe = 1'b1;
    acq_len = 8'd3; rel_len = 8'd2;
    m_held = 0; m_cnt = 0; m_sc = 0; m_code = 0; m_guard = 0; m_dv = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state seen through the ports
    check("R1 bus_code after reset", bus_code, 0);
    check("R1 guard after reset", guard, 0);
    check("R1 digit_valid after reset", digit_valid, 0);

    // R3: burst one cycle short of acq_len
    step(1, 4'd5, 1); step(1, 4'd5, 1); step(0, 4'd5, 1);
    check("R3 short burst ignored", bus_code, 0);
    check("R3 no valid after short burst", digit_valid, 0);

    // R2: exact acquisition
    step(1, 4'd9, 1); step(1, 4'd9, 1); step(1, 4'd9, 1);
    check("R2 code latched", bus_code, 9);
    check("R4 guard after latch", guard, 1);
    check("R5 not yet valid at latch", digit_valid, 0);
    // R7: code changes during hold
    step(1, 4'd3, 1);
    step(1, 4'd3, 1);
    check("R5 valid after settle", digit_valid, 1);
    check("R7 latch held", bus_code, 9);
    // R6: dropout shorter than rel_len
    step(0, 4'd3, 1);
    check("R4 guard drops with tone", guard, 0);
    step(1, 4'd3, 1);
    check("R6 short dropout keeps digit", digit_valid, 1);
    // R8: bus off
    step(1, 4'd3, 0);
    check("R8 bus quiet when disabled", bus_code, 0);
    // R6: full release
    step(0, 4'd3, 1); step(0, 4'd3, 1);
    check("R6 released", digit_valid, 0);
    check("R7 code kept after release", bus_code, 9);

    // R9: zero lengths act as one
    acq_len = 8'd0; rel_len = 8'd0;
    step(1, 4'd15, 1);
    check("R9 single cycle acquire", bus_code, 15);
    step(0, 4'd15, 1);
    check("R9 single cycle release", guard, 0);
    step(1, 4'd0, 1);
    check("R9 new digit after release", bus_code, 0);
    step(0, 4'd0, 1);

    // R2: every code value
    acq_len = 8'd2; rel_len = 8'd2;
    for (int c = 0; c < 16; c++) begin
      step(1, 4'(c), 1); step(1, 4'(c), 1);
      check("R2 code value", bus_code, c);
      step(0, 4'(c), 1); step(0, 4'(c), 1);
    end

    // random: bursts and gaps around the programmed counts
    for (int r = 0; r < 60; r++) begin
      acq_len = 8'($urandom_range(0, 5));
      rel_len = 8'($urandom_range(0, 5));
      for (int b = 0; b < 12; b++) begin
        int len = $urandom_range(1, 7);
        bit tp  = b[0] ^ 1'b1;
        bit [3:0] tc = 4'($urandom_range(0, 15));
        for (int k = 0; k < len; k++) begin
          if ($urandom_range(0, 9) == 0) tc = 4'($urandom_range(0, 15));
          step(tp, tc, ($urandom_range(0, 3) != 0));
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule